// File: doc/BRIEF.md
# Link Error Logging and Reporting Registers

This block keeps the error record for one function of a serial-link endpoint. Detection logic elsewhere raises one-cycle pulses on twelve uncorrectable and six correctable error sources. The block records each unmasked pulse in a sticky status bit and sorts uncorrectable errors into fatal or non-fatal classes through a per-source severity bit. It drives three level flags and a one-cycle report request that a message generator can act on.

Software reaches the registers through a plain single-cycle write strobe, an address, write data and combinational read data. Status registers clear when 1s are written to them. Mask and severity registers are ordinary read/write registers. A control word shows the ECRC capabilities, which are fixed by parameters, and the ECRC enables, which software can change. The same word carries a pointer that records which uncorrectable error came first. ECRC arithmetic, message formation, header logging and link-layer detection all sit outside this block.

Top module: `link_err_log`

## Requirements
- R1: After reset the registers read as follows: uncorrectable status 0, uncorrectable mask 0, severity 0x18B, correctable status 0, correctable mask 0x20, and control 0x50 with the default parameters. All three flags and `report_pulse` are 0.
- R2: Uncorrectable source index order is: 0 data-link protocol, 1 surprise down, 2 poisoned TLP, 3 flow-control protocol, 4 completion timeout, 5 completer abort, 6 unexpected completion, 7 receiver overflow, 8 malformed TLP, 9 ECRC error, 10 unsupported request, 11 ACS violation. An unmasked pulse on `unc_evt[i]` sets status bit i at that clock edge, and the bit stays set until software clears it.
- R3: Status registers clear on a write of 1. Each written 1 clears its bit and each written 0 leaves its bit unchanged. An event arriving in the same cycle as a clear of the same bit keeps that bit set.
- R4: A source whose mask bit is 1 is neither recorded nor reported. The correctable mask resets with only bit 5 set. Bit 5 is the advisory non-fatal source, and the correctable order is 0 receiver error, 1 bad TLP, 2 bad DLLP, 3 replay-number rollover, 4 replay-timer timeout, 5 advisory non-fatal.
- R5: `flag_fatal` is the OR of the uncorrectable status bits that are both unmasked and have severity 1. `flag_nonfatal` is the same OR over bits with severity 0. Both flags follow the current contents of the mask and severity registers.
- R6: `flag_cor` is the OR of the unmasked correctable status bits.
- R7: `report_pulse` is high for exactly the one cycle after a clock edge at which an unmasked error of either class was recorded.
- R8: The first-error pointer is held in control bits [3:0]. It loads the lowest index among the unmasked uncorrectable pulses only when the uncorrectable status register is entirely clear. While any status bit is set, the pointer holds its value.
- R9: Control bit 4 is ECRC generation capable and bit 6 is ECRC check capable. Both are read-only and come from parameters. Bits 5 and 7 are the generation and check enables. Each enable is writable when its capability is set and reads 0 otherwise.
- R10: The register addresses are 0 uncorrectable status, 1 uncorrectable mask, 2 severity, 3 correctable status, 4 correctable mask and 5 control. Any other address reads 0. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unc_evt | input | 12 | Uncorrectable detection pulses |
| cor_evt | input | 6 | Correctable detection pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| flag_cor | output | 1 | Unmasked correctable error present |
| flag_nonfatal | output | 1 | Unmasked non-fatal uncorrectable error present |
| flag_fatal | output | 1 | Unmasked fatal uncorrectable error present |
| report_pulse | output | 1 | One-cycle report request |

## Verification
The hardest situations to reach are the first-error pointer refusing to move while older errors are still logged, and a clear racing an arriving event on the same bit. Both depend on the exact relative cycle of a register write and a detection pulse. The stimulus builds them deliberately. It logs several errors at once to check that the lowest index wins. It then fires a lower index while status is non-empty and expects the pointer to stay put. Finally it drives a write-1 clear and the matching pulse on the same negedge, so that both land on one edge.

// File: rtl/link_err_pkg.sv
`timescale 1ns/1ps
package link_err_pkg;
  localparam int UNC_N  = 12;
  localparam int COR_N  = 6;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int PTR_W  = $clog2(UNC_N);

  typedef enum logic [ADDR_W-1:0] {
    A_UNC_STAT = 3'd0,
    A_UNC_MASK = 3'd1,
    A_UNC_SEV  = 3'd2,
    A_COR_STAT = 3'd3,
    A_COR_MASK = 3'd4,
    A_CTRL     = 3'd5
  } reg_addr_e;

  // control word bit positions
  localparam int CTL_GCAP = PTR_W;
  localparam int CTL_GEN  = PTR_W + 1;
  localparam int CTL_CCAP = PTR_W + 2;
  localparam int CTL_CEN  = PTR_W + 3;

  localparam logic [UNC_N-1:0] SEV_RST_DEF      = 12'h18B;
  localparam logic [COR_N-1:0] COR_MASK_RST_DEF = 6'h20;
endpackage

// File: rtl/rw_reg.sv
`timescale 1ns/1ps
module rw_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/err_bank.sv
`timescale 1ns/1ps
module err_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] hit
);
  logic [W-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    hit     = evt & ~mask_q;
    stat_d  = (stat_q & ~(clr_we ? wd : '0)) | hit;
    stat_en = clr_we | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  rw_reg #(.W(W), .RST(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wd(wd), .q(mask_q)
  );
endmodule

// File: rtl/first_err_ptr.sv
`timescale 1ns/1ps
module first_err_ptr #(
  parameter int W  = 12,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  stat_q,
  input  logic [W-1:0]  hit,
  output logic [PW-1:0] ptr_q
);
  logic [PW-1:0] low;
  logic          ptr_en;

  always_comb begin
    low = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit[i]) low = PW'(i);
    end
    ptr_en = (stat_q == '0) && (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= low;
  end
endmodule

// File: rtl/link_err_log.sv
`timescale 1ns/1ps
module link_err_log
  import link_err_pkg::*;
#(
  parameter bit GEN_CAP = 1'b1,
  parameter bit CHK_CAP = 1'b1,
  parameter logic [UNC_N-1:0] SEV_RESET      = SEV_RST_DEF,
  parameter logic [COR_N-1:0] COR_MASK_RESET = COR_MASK_RST_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UNC_N-1:0]  unc_evt,
  input  logic [COR_N-1:0]  cor_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              flag_cor,
  output logic              flag_nonfatal,
  output logic              flag_fatal,
  output logic              report_pulse
);
  logic we_ustat, we_umask, we_usev, we_cstat, we_cmask, we_ctl;
  logic [UNC_N-1:0] unc_stat_q, unc_mask_q, unc_sev_q, unc_hit, unc_live;
  logic [COR_N-1:0] cor_stat_q, cor_mask_q, cor_hit;
  logic [PTR_W-1:0] first_ptr_q;
  logic             gen_en_q, chk_en_q;
  logic             rep_d, rep_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:UNC_N];

  always_comb begin
    we_ustat = reg_wr && (reg_addr == A_UNC_STAT);
    we_umask = reg_wr && (reg_addr == A_UNC_MASK);
    we_usev  = reg_wr && (reg_addr == A_UNC_SEV);
    we_cstat = reg_wr && (reg_addr == A_COR_STAT);
    we_cmask = reg_wr && (reg_addr == A_COR_MASK);
    we_ctl   = reg_wr && (reg_addr == A_CTRL);
  end

  err_bank #(.W(UNC_N), .MASK_RST('0)) u_unc (
    .clk(clk), .rst_n(rst_n), .evt(unc_evt),
    .mask_we(we_umask), .clr_we(we_ustat), .wd(reg_wdata[UNC_N-1:0]),
    .stat_q(unc_stat_q), .mask_q(unc_mask_q), .hit(unc_hit)
  );

  err_bank #(.W(COR_N), .MASK_RST(COR_MASK_RESET)) u_cor (
    .clk(clk), .rst_n(rst_n), .evt(cor_evt),
    .mask_we(we_cmask), .clr_we(we_cstat), .wd(reg_wdata[COR_N-1:0]),
    .stat_q(cor_stat_q), .mask_q(cor_mask_q), .hit(cor_hit)
  );

  rw_reg #(.W(UNC_N), .RST(SEV_RESET)) u_sev (
    .clk(clk), .rst_n(rst_n), .we(we_usev),
    .wd(reg_wdata[UNC_N-1:0]), .q(unc_sev_q)
  );

  first_err_ptr #(.W(UNC_N), .PW(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .stat_q(unc_stat_q), .hit(unc_hit),
    .ptr_q(first_ptr_q)
  );

  // enable bits exist only when the matching capability does
  generate
    if (GEN_CAP) begin : g_gen_en
      rw_reg #(.W(1), .RST(1'b0)) u_gen (
        .clk(clk), .rst_n(rst_n), .we(we_ctl),
        .wd(reg_wdata[CTL_GEN]), .q(gen_en_q)
      );
    end else begin : g_gen_off
      assign gen_en_q = 1'b0;
    end
    if (CHK_CAP) begin : g_chk_en
      rw_reg #(.W(1), .RST(1'b0)) u_chk (
        .clk(clk), .rst_n(rst_n), .we(we_ctl),
        .wd(reg_wdata[CTL_CEN]), .q(chk_en_q)
      );
    end else begin : g_chk_off
      assign chk_en_q = 1'b0;
    end
  endgenerate

  always_comb begin
    unc_live      = unc_stat_q & ~unc_mask_q;
    flag_fatal    = |(unc_live & unc_sev_q);
    flag_nonfatal = |(unc_live & ~unc_sev_q);
    flag_cor      = |(cor_stat_q & ~cor_mask_q);
    rep_d         = (|unc_hit) | (|cor_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= 1'b0;
    else        rep_q <= rep_d;
  end
  assign report_pulse = rep_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_UNC_STAT: reg_rdata[UNC_N-1:0] = unc_stat_q;
      A_UNC_MASK: reg_rdata[UNC_N-1:0] = unc_mask_q;
      A_UNC_SEV:  reg_rdata[UNC_N-1:0] = unc_sev_q;
      A_COR_STAT: reg_rdata[COR_N-1:0] = cor_stat_q;
      A_COR_MASK: reg_rdata[COR_N-1:0] = cor_mask_q;
      A_CTRL: begin
        reg_rdata[PTR_W-1:0] = first_ptr_q;
        reg_rdata[CTL_GCAP]  = GEN_CAP;
        reg_rdata[CTL_GEN]   = gen_en_q;
        reg_rdata[CTL_CCAP]  = CHK_CAP;
        reg_rdata[CTL_CEN]   = chk_en_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/link_err_log_chk.sv
`timescale 1ns/1ps
module link_err_log_chk
  import link_err_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [UNC_N-1:0]  unc_evt,
  input logic [COR_N-1:0]  cor_evt,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [UNC_N-1:0]  unc_stat,
  input logic [UNC_N-1:0]  unc_mask,
  input logic [COR_N-1:0]  cor_stat,
  input logic [COR_N-1:0]  cor_mask,
  input logic [PTR_W-1:0]  first_ptr,
  input logic              flag_cor,
  input logic              flag_fatal,
  input logic              report_pulse
);
  logic [UNC_N-1:0] unc_clr;
  logic             any_new;

  always_comb begin
    unc_clr = (reg_wr && reg_addr == A_UNC_STAT) ? reg_wdata[UNC_N-1:0] : '0;
    any_new = (|(unc_evt & ~unc_mask)) | (|(cor_evt & ~cor_mask));
  end

  // R2, R4: a newly set status bit came from an unmasked pulse
  assert_unc_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((unc_stat & ~$past(unc_stat)) & ~$past(unc_evt & ~unc_mask)) == '0);

  // R3: a status bit only drops after a 1 is written to it
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(unc_stat) & ~unc_stat) & ~$past(unc_clr)) == '0);

  // R5: fatal flag needs some logged uncorrectable error
  assert_fatal_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_fatal |-> (unc_stat != '0));

  // R6: correctable flag needs some logged correctable error
  assert_cor_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cor |-> (cor_stat != '0));

  // R7: report follows an unmasked detection one cycle earlier
  assert_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_new |=> report_pulse);

  // R8: pointer frozen while uncorrectable status holds a bit
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(unc_stat) != '0) |-> $stable(first_ptr));

  // R9: capability bits never change across reads of the control word
  assert_cap_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL && $past(reg_addr) == A_CTRL) |->
      (reg_rdata[CTL_GCAP] == $past(reg_rdata[CTL_GCAP]) &&
       reg_rdata[CTL_CCAP] == $past(reg_rdata[CTL_CCAP])));
endmodule

bind link_err_log link_err_log_chk u_chk (
  .clk(clk), .rst_n(rst_n), .unc_evt(unc_evt), .cor_evt(cor_evt),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .unc_stat(unc_stat_q), .unc_mask(unc_mask_q),
  .cor_stat(cor_stat_q), .cor_mask(cor_mask_q), .first_ptr(first_ptr_q),
  .flag_cor(flag_cor), .flag_fatal(flag_fatal), .report_pulse(report_pulse)
);

// File: tb/link_err_log_tb.sv
`timescale 1ns/1ps
module link_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] unc_evt = '0;
  logic [5:0]  cor_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        flag_cor, flag_nonfatal, flag_fatal, report_pulse;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  link_err_log u_dut (
    .clk(clk), .rst_n(rst_n), .unc_evt(unc_evt), .cor_evt(cor_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flag_cor(flag_cor), .flag_nonfatal(flag_nonfatal),
    .flag_fatal(flag_fatal), .report_pulse(report_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // drive pulses for one edge; rep sampled in the cycle after that edge
  task automatic fire(input logic [11:0] u, input logic [5:0] c, output logic rep);
    @(negedge clk);
    unc_evt = u; cor_evt = c;
    @(negedge clk);
    unc_evt = '0; cor_evt = '0;
    rep = report_pulse;
  endtask

  localparam logic [11:0] SEV0 = 12'h18B;

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic rep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R10 map
    rd(3'd0, d); check("R1 unc status", d, 32'h0);
    rd(3'd1, d); check("R1 unc mask", d, 32'h0);
    rd(3'd2, d); check("R1 severity", d, 32'h18B);
    rd(3'd3, d); check("R1 cor status", d, 32'h0);
    rd(3'd4, d); check("R1 cor mask", d, 32'h20);
    rd(3'd5, d); check("R1 control", d, 32'h50);
    rd(3'd6, d); check("R10 unmapped 6", d, 32'h0);
    rd(3'd7, d); check("R10 unmapped 7", d, 32'h0);
    check("R1 flags", {flag_cor, flag_nonfatal, flag_fatal, report_pulse}, 4'h0);

    // sweep every uncorrectable source
    for (int i = 0; i < 12; i++) begin
      fire(12'(1 << i), 6'h0, rep);
      check("R7 report unc", rep, 1'b1);
      check("R5 fatal", flag_fatal, SEV0[i]);
      check("R5 nonfatal", flag_nonfatal, !SEV0[i]);
      rd(3'd0, d); check("R2 status bit", d, 32'(1 << i));
      check("R7 one cycle", report_pulse, 1'b0);
      rd(3'd5, d); check("R8 pointer", d & 32'hF, 32'(i));
      wr(3'd0, 32'h0);
      rd(3'd0, d); check("R3 write zero no effect", d, 32'(1 << i));
      wr(3'd0, 32'(1 << i));
      rd(3'd0, d); check("R3 cleared", d, 32'h0);
      check("R5 flags idle", {flag_fatal, flag_nonfatal}, 2'b00);
    end

    // sweep every correctable source; bit 5 masked by default
    for (int j = 0; j < 6; j++) begin
      fire(12'h0, 6'(1 << j), rep);
      check("R7 report cor", rep, (j != 5));
      check("R6 cor flag", flag_cor, (j != 5));
      rd(3'd3, d); check("R4 cor status", d, (j != 5) ? 32'(1 << j) : 32'h0);
      wr(3'd3, 32'h3F);
      rd(3'd3, d); check("R3 cor cleared", d, 32'h0);
    end

    // R8 simultaneous: lowest index wins; then held while status non-empty
    fire(12'h0A4, 6'h0, rep);
    rd(3'd5, d); check("R8 lowest of many", d & 32'hF, 32'd2);
    fire(12'h001, 6'h0, rep);
    rd(3'd5, d); check("R8 held", d & 32'hF, 32'd2);
    rd(3'd0, d); check("R2 accumulate", d, 32'h0A5);
    wr(3'd0, 32'h004);
    fire(12'h800, 6'h0, rep);
    rd(3'd5, d); check("R8 not rearmed", d & 32'hF, 32'd2);
    wr(3'd0, 32'hFFF);
    fire(12'h200, 6'h0, rep);
    rd(3'd5, d); check("R8 rearmed", d & 32'hF, 32'd9);
    wr(3'd0, 32'hFFF);

    // R4 uncorrectable masking
    wr(3'd1, 32'h00F);
    fire(12'h00F, 6'h0, rep);
    check("R4 masked no report", rep, 1'b0);
    rd(3'd0, d); check("R4 masked not logged", d, 32'h0);
    fire(12'h011, 6'h0, rep);
    rd(3'd0, d); check("R4 partial mask", d, 32'h010);
    rd(3'd5, d); check("R8 masked skipped", d & 32'hF, 32'd4);
    wr(3'd0, 32'hFFF);
    wr(3'd1, 32'h000);

    // R5 flags follow severity and mask changes
    wr(3'd2, 32'h000);
    fire(12'h001, 6'h0, rep);
    check("R5 sev0 nonfatal", {flag_fatal, flag_nonfatal}, 2'b01);
    wr(3'd2, 32'hFFF);
    check("R5 sev1 fatal", {flag_fatal, flag_nonfatal}, 2'b10);
    wr(3'd1, 32'h001);
    check("R5 masked after log", {flag_fatal, flag_nonfatal}, 2'b00);
    rd(3'd0, d); check("R5 status kept", d, 32'h001);
    wr(3'd1, 32'h000);
    wr(3'd0, 32'hFFF);
    wr(3'd2, 32'h18B);

    // R3 clear and event on the same edge: bit stays set
    fire(12'h002, 6'h0, rep);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h002; unc_evt = 12'h002;
    @(negedge clk);
    reg_wr = 1'b0; unc_evt = '0;
    rd(3'd0, d); check("R3 set wins", d, 32'h002);
    wr(3'd0, 32'hFFF);

    // R6 unmasking advisory source
    wr(3'd4, 32'h00);
    fire(12'h0, 6'h20, rep);
    check("R6 advisory flag", flag_cor, 1'b1);
    wr(3'd3, 32'h3F);
    wr(3'd4, 32'h20);

    // R9 control enables
    rd(3'd5, d);
    wr(3'd5, 32'hFF);
    rd(3'd5, d); check("R9 enables set", d & 32'hF0, 32'hF0);
    wr(3'd5, 32'h00);
    rd(3'd5, d); check("R9 caps read-only", d & 32'hF0, 32'h50);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule